// File: doc/BRIEF.md
# UART Interrupt Status and Routing

This block holds the interrupt state of a memory-mapped serial port. Eleven source bits gather events from the surrounding receive, transmit, modem and line-error logic. Each bit is set by a one-cycle pulse and stays set until software clears it. A software-written enable mask selects which of these latched bits may raise an interrupt. Software reads the latched status either raw or filtered through the mask, and clears it by writing ones to a clear register.

Six registered interrupt lines leave the block. Line 0 is the combined request. Lines 1 to 5 each cover one group of sources, so that an interrupt controller can route each group to its own handler. The register port is a plain single-cycle 32-bit word interface. It has no valid/ready handshake: a write strobe takes effect at the next clock edge, and read data is a combinational function of the address that has no side effects. Nothing flows through the block as a stream, so it has no back-pressure.

Top module: `uart_irq_ctrl`

## Requirements
- R1: On reset, the enable mask, the raw status and all six interrupt lines are zero.
- R2: The enable mask is read and written at word address 1. Only bits 10:0 are stored; upper bits read as zero. The other word addresses are 0 for data, 2 for raw status, 3 for masked status and 4 for clear. Any other address reads zero.
- R3: A read of address 3 returns the raw status ANDed with the enable mask.
- R4: A write to address 4 clears every raw status bit whose written bit is 1 and leaves the other bits unchanged. A read of address 4 always returns 0.
- R5: Writes to address 2 and address 3 change neither the raw status nor the mask.
- R6: A one-cycle pulse on `src_set[i]` sets raw bit i, which then stays set until cleared. The bit layout is: 0 receive, 1 transmit, 2 receive timeout, 3..6 modem status (ring, clear-to-send, carrier detect, data-set-ready), 7..10 errors (framing, parity, break, overrun).
- R7: Every write to address 0 sets raw bit 1 (transmit).
- R8: When a set pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R9: `irq_out[0]` is asserted when any masked bit is set. `irq_out[1]` to `irq_out[5]` are asserted when any masked bit of the receive, transmit, timeout, modem or error group is set. Each line updates on the clock edge that follows the edge that changed the status or the mask.
- R10: A change of the enable mask alone, with the raw status held, raises or drops the lines on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Word address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| src_set | input | 11 | Set pulses from the source logic |
| irq_out | output | 6 | Interrupt lines: combined, receive, transmit, timeout, modem, error |

## Verification
The bench drives a set pulse and a clear write onto the same bit in one cycle. A design that gives the clear priority would lose that event, and the bit would read back as zero. It checks each line in the cycle right after the status edge and again one cycle later. A design with combinational lines, or with two register stages, would show its lines one cycle off. It writes to both status views and to the mask with out-of-range upper bits, which catches decode that lets those writes through or stores bits that do not exist. It also drops the mask while the status is held, which catches a line driven from the raw status instead of the masked one.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC   = 11;
  localparam int NLINES = 6;

  localparam int B_RX  = 0;
  localparam int B_TX  = 1;
  localparam int B_RT  = 2;
  localparam int B_MS0 = 3;
  localparam int B_ER0 = 7;
  localparam int GRP_W = 4;

  localparam logic [NSRC-1:0] M_ALL = {NSRC{1'b1}};
  localparam logic [NSRC-1:0] M_RX  = NSRC'(1) << B_RX;
  localparam logic [NSRC-1:0] M_TX  = NSRC'(1) << B_TX;
  localparam logic [NSRC-1:0] M_RT  = NSRC'(1) << B_RT;
  localparam logic [NSRC-1:0] M_MS  = NSRC'((1 << GRP_W) - 1) << B_MS0;
  localparam logic [NSRC-1:0] M_ER  = NSRC'((1 << GRP_W) - 1) << B_ER0;

  // index 0 = combined, 1..5 = per group
  localparam logic [NLINES-1:0][NSRC-1:0] LINE_SEL = {M_ER, M_MS, M_RT, M_TX, M_RX, M_ALL};

  localparam int OFS_DATA  = 0;
  localparam int OFS_MASK  = 1;
  localparam int OFS_RAW   = 2;
  localparam int OFS_MSKD  = 3;
  localparam int OFS_CLEAR = 4;
endpackage

// File: rtl/uart_irq_decode.sv
module uart_irq_decode
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   mask_q,
  input  logic [NSRC-1:0]   raw_q,
  output logic              mask_we,
  output logic              clr_we,
  output logic              data_we,
  output logic [NSRC-1:0]   wbits
);
  localparam int PAD_W = DATA_W - NSRC;

  logic sel_data, sel_mask, sel_raw, sel_mskd;
  logic unused_hi;

  assign sel_data = (bus_addr == ADDR_W'(OFS_DATA));
  assign sel_mask = (bus_addr == ADDR_W'(OFS_MASK));
  assign sel_raw  = (bus_addr == ADDR_W'(OFS_RAW));
  assign sel_mskd = (bus_addr == ADDR_W'(OFS_MSKD));

  assign mask_we = bus_wr && sel_mask;
  assign clr_we  = bus_wr && (bus_addr == ADDR_W'(OFS_CLEAR));
  assign data_we = bus_wr && sel_data;
  assign wbits   = bus_wdata[NSRC-1:0];
  assign unused_hi = ^bus_wdata[DATA_W-1:NSRC];

  always_comb begin
    bus_rdata = '0;
    if (sel_mask)      bus_rdata = {{PAD_W{1'b0}}, mask_q};
    else if (sel_raw)  bus_rdata = {{PAD_W{1'b0}}, raw_q};
    else if (sel_mskd) bus_rdata = {{PAD_W{1'b0}}, raw_q & mask_q};
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mask_we, clr_we, data_we}));
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_we,
  input  logic            clr_we,
  input  logic            data_we,
  input  logic [NSRC-1:0] wbits,
  input  logic [NSRC-1:0] src_set,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] raw_q
);
  logic [NSRC-1:0] clr_bits, set_bits, raw_d;

  assign clr_bits = clr_we ? wbits : '0;
  assign set_bits = src_set | (data_we ? M_TX : '0);
  // set has priority over clear
  assign raw_d    = (raw_q & ~clr_bits) | set_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      raw_q  <= '0;
    end else begin
      raw_q <= raw_d;
      if (mask_we) mask_q <= wbits;
    end
  end

  // R8
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set != '0) |=> ((raw_q & $past(src_set)) == $past(src_set)));
  // R4
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !data_we) |=> ((raw_q & $past(wbits) & ~$past(src_set)) == '0));
  // R7
  tx_on_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> raw_q[B_TX]);
  // R5
  raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we && !data_we && src_set == '0) |=> (raw_q == $past(raw_q)));
  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> (mask_q == $past(mask_q)));
endmodule

// File: rtl/uart_irq_route.sv
module uart_irq_route
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   mask_q,
  input  logic [NSRC-1:0]   raw_q,
  output logic [NLINES-1:0] irq_out
);
  logic [NSRC-1:0] active;
  assign active = raw_q & mask_q;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_out[g] <= 1'b0;
      else        irq_out[g] <= |(active & LINE_SEL[g]);
    end
  end

  // R9
  combined_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out[0] == |($past(raw_q) & $past(mask_q))));
  // R9
  group_within_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out[NLINES-1:1] != '0) |-> irq_out[0]);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   src_set,
  output logic [NLINES-1:0] irq_out
);
  logic            mask_we, clr_we, data_we;
  logic [NSRC-1:0] wbits, mask_q, raw_q;

  uart_irq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mask_q(mask_q),
    .raw_q(raw_q), .mask_we(mask_we), .clr_we(clr_we), .data_we(data_we),
    .wbits(wbits)
  );

  uart_irq_status u_stat (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .clr_we(clr_we),
    .data_we(data_we), .wbits(wbits), .src_set(src_set),
    .mask_q(mask_q), .raw_q(raw_q)
  );

  uart_irq_route u_route (
    .clk(clk), .rst_n(rst_n), .mask_q(mask_q), .raw_q(raw_q), .irq_out(irq_out)
  );
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [10:0] src_set = '0;
  logic [5:0]  irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  uart_irq_ctrl i_uart_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_set(src_set),
    .irq_out(irq_out)
  );

  // op: 0 write, 1 read check, 2 set pulse, 3 line check after one edge
  localparam int N = 24;
  localparam logic [73:0] TBL [N] = '{
    {2'd0, 4'd2,  4'd1, 32'h0000_07FF, 32'h0},           // R2
    {2'd1, 4'd2,  4'd1, 32'h0,         32'h0000_07FF},   // R2
    {2'd0, 4'd2,  4'd1, 32'hFFFF_FFFF, 32'h0},           // R2
    {2'd1, 4'd2,  4'd1, 32'h0,         32'h0000_07FF},   // R2 upper bits dropped
    {2'd1, 4'd2,  4'd7, 32'h0,         32'h0},           // R2 unmapped
    {2'd2, 4'd6,  4'd0, 32'h0000_0001, 32'h0},           // R6
    {2'd1, 4'd6,  4'd2, 32'h0,         32'h0000_0001},   // R6
    {2'd3, 4'd9,  4'd0, 32'h0,         32'h0000_0003},   // R9 any + rx
    {2'd0, 4'd10, 4'd1, 32'h0,         32'h0},           // R10
    {2'd1, 4'd3,  4'd3, 32'h0,         32'h0},           // R3
    {2'd1, 4'd6,  4'd2, 32'h0,         32'h0000_0001},   // R6 held
    {2'd3, 4'd10, 4'd0, 32'h0,         32'h0},           // R10 line drops
    {2'd0, 4'd2,  4'd1, 32'h0000_07F8, 32'h0},           // R2
    {2'd2, 4'd6,  4'd0, 32'h0000_00A8, 32'h0},           // R6
    {2'd1, 4'd3,  4'd3, 32'h0,         32'h0000_00A8},   // R3
    {2'd3, 4'd9,  4'd0, 32'h0,         32'h0000_0031},   // R9 any + modem + error
    {2'd0, 4'd5,  4'd2, 32'h0,         32'h0},           // R5
    {2'd0, 4'd5,  4'd3, 32'h0000_07FF, 32'h0},           // R5
    {2'd1, 4'd5,  4'd2, 32'h0,         32'h0000_00A9},   // R5
    {2'd0, 4'd4,  4'd4, 32'h0000_0009, 32'h0},           // R4
    {2'd1, 4'd4,  4'd2, 32'h0,         32'h0000_00A0},   // R4
    {2'd1, 4'd4,  4'd4, 32'h0,         32'h0},           // R4 reads zero
    {2'd0, 4'd7,  4'd0, 32'h0000_0055, 32'h0},           // R7
    {2'd1, 4'd7,  4'd2, 32'h0,         32'h0000_00A2}    // R7
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input int req, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [10:0] s);
    @(negedge clk);
    src_set = s;
    @(negedge clk);
    src_set = '0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 state while held in reset and after release
    rd_chk(1, 4'd1, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk(1, 4'd2, 32'h0);
    check(1, {26'h0, irq_out}, 32'h0);

    for (int i = 0; i < N; i++) begin
      logic [73:0] e;
      e = TBL[i];
      case (e[73:72])
        2'd0: wr(e[67:64], e[63:32]);
        2'd1: rd_chk(int'(e[71:68]), e[67:64], e[31:0]);
        2'd2: pulse(e[42:32]);
        default: begin
          @(negedge clk);
          check(int'(e[71:68]), {26'h0, irq_out}, e[31:0]);
        end
      endcase
    end

    // R9: transmit line and one-cycle latency
    wr(4'd1, 32'h0000_0002);
    @(negedge clk);
    check(9, {26'h0, irq_out}, 32'h0000_0005);
    wr(4'd4, 32'h0000_07FF);
    rd_chk(4, 4'd2, 32'h0);
    check(9, {26'h0, irq_out}, 32'h0000_0005);   // old value still held
    @(negedge clk);
    check(9, {26'h0, irq_out}, 32'h0);

    // R8: set and clear on the same bit in one cycle
    wr(4'd1, 32'h0000_0004);
    @(negedge clk);
    bus_addr = 4'd4; bus_wdata = 32'h0000_0004; bus_wr = 1'b1; src_set = 11'h004;
    @(negedge clk);
    bus_wr = 1'b0; src_set = '0;
    rd_chk(8, 4'd2, 32'h0000_0004);
    check(9, {26'h0, irq_out}, 32'h0);           // R9 not yet registered
    @(negedge clk);
    check(9, {26'h0, irq_out}, 32'h0000_0009);   // any + timeout

    // R1: reset in mid-run clears everything
    rst_n = 1'b0;
    #1;
    check(1, {26'h0, irq_out}, 32'h0);
    rd_chk(1, 4'd1, 32'h0);
    rd_chk(1, 4'd2, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule